// File: doc/BRIEF.md
# I2C Wiper Register Slave

This block is an I2C target that gives a host access to a small bank of 8-bit wiper settings and one control register. It runs on a fast system clock and oversamples the SCL and SDA pins through synchronizers. It drives SDA only by pulling it low, through an open-drain enable. A transaction opens with an identification byte. Its upper nibble is fixed and the next three bits must match three strap pins. For a write, a register-pointer byte follows the identification byte, and then data bytes. For a read, data is returned from the current pointer. The pointer advances after every byte that is written, and after every read byte that the host acknowledges.

The control register can launch a simulated nonvolatile store. A countdown timer then holds a read-only busy flag high for a fixed number of clocks. While the flag is high, the block acknowledges write data but does not change any register. All wiper values are presented in parallel on an output bus for the analog side.

Top module: `i2c_wiper_regs`

## Requirements
- R1: Every byte on SDA travels most-significant bit first, in both directions.
- R2: A START (SDA falls while SCL is high) restarts decoding at the identification byte from any state, including a repeated START partway through a transfer. A STOP (SDA rises while SCL is high) returns the slave to standby with SDA released.
- R3: SCL and SDA activity that is not preceded by a START never causes the slave to drive SDA.
- R4: The identification byte matches only when bits 7:4 equal 1010 and bits 3:1 equal `addr_pins`. Bit 0 is 1 for a read and 0 for a write. On a mismatch the slave leaves SDA released on the ninth clock and ignores the bus until the next START.
- R5: The slave pulls SDA low on the ninth clock after a matching identification byte, after the register-pointer byte, and after each write data byte.
- R6: During a read the slave shifts out the register at the pointer on eight clocks and releases SDA on the ninth clock. Each host acknowledge advances the pointer and starts the next byte.
- R7: A host NACK on a read ends the transfer. SDA stays released until the next STOP or START.
- R8: Pointer values 0 to NUM_WIPERS-1 select the wiper registers and 0x08 selects the control register. Other pointer values read as 0x00 and ignore writes. The pointer increments after each write data byte.
- R9: Control register layout: bit 7 is a store request that reads back as 0, bit 5 is the read-only busy flag, and bits 6 and 4:0 are read/write. Writing bit 7 as 1 while not busy sets busy for STORE_CYCLES clocks, after which it clears by itself.
- R10: While busy is 1, writes to the wiper registers and to the control register leave them unchanged. The data bytes are still acknowledged.
- R11: After reset SDA is released, every wiper holds 0x80 and the control register reads 0x00. A START that occurs within RESET_HOLD clocks after reset is ignored.
- R12: The slave changes its SDA drive only while SCL is low, apart from the release that follows a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired bus) |
| addr_pins | input | 3 | Strap pins compared with identification bits 3:1 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_o | output | NUM_WIPERS*8 | Wiper registers, wiper i at bits 8i+7:8i |

## Verification
The hardest case to reach is a write that arrives while the store timer is running. The flag is only set by a full control-register write, and it clears by itself. Every rejected write and every busy read-back must therefore fit inside that window. The bench shortens STORE_CYCLES through a parameter and issues the store, a busy read, a wiper write and a control write back to back. It then waits out the timer and repeats the write to show that it takes effect afterwards.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam logic [3:0] ID_PREFIX    = 4'b1010;
  localparam logic [7:0] CTRL_ADDR    = 8'h08;
  localparam int         BUSY_BIT     = 5;
  localparam int         STORE_BIT    = 7;
  localparam logic [7:0] CTRL_RW_MASK = 8'h5F;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_REG, S_REG_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK, S_WAIT
  } bus_state_t;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/wiper_regfile.sv
module wiper_regfile #(
  parameter int         NUM_WIPERS   = 4,
  parameter int         STORE_CYCLES = 50000,
  parameter logic [7:0] WIPER_RESET  = 8'h80
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [7:0]              wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [7:0]              rd_addr,
  output logic [7:0]              rd_data,
  output logic                    busy,
  output logic [NUM_WIPERS*8-1:0] wiper_flat
);
  import wiper_pkg::*;

  localparam int TW = $clog2(STORE_CYCLES + 1);
  localparam int IW = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;

  logic [7:0]    wipers [NUM_WIPERS];
  logic [7:0]    ctrl_q;
  logic [TW-1:0] timer;
  logic          wr_ok;
  logic [7:0]    ctrl_view;

  assign busy  = (timer != '0);
  assign wr_ok = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WIPERS; i++) wipers[i] <= WIPER_RESET;
      ctrl_q <= '0;
      timer  <= '0;
    end else begin
      if (busy) timer <= timer - TW'(1);
      if (wr_ok) begin
        if (int'(wr_addr) < NUM_WIPERS) begin
          wipers[wr_addr[IW-1:0]] <= wr_data;
        end else if (wr_addr == CTRL_ADDR) begin
          ctrl_q <= wr_data & CTRL_RW_MASK;
          if (wr_data[STORE_BIT]) timer <= TW'(STORE_CYCLES);
        end
      end
    end
  end

  always_comb begin
    ctrl_view           = ctrl_q;
    ctrl_view[BUSY_BIT] = busy;
    if (int'(rd_addr) < NUM_WIPERS) rd_data = wipers[rd_addr[IW-1:0]];
    else if (rd_addr == CTRL_ADDR)  rd_data = ctrl_view;
    else                            rd_data = 8'h00;
  end

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_out
    assign wiper_flat[g*8 +: 8] = wipers[g];
  end
endmodule

// File: rtl/i2c_wiper_regs.sv
module i2c_wiper_regs #(
  parameter int         NUM_WIPERS   = 4,
  parameter int         STORE_CYCLES = 50000,
  parameter int         RESET_HOLD   = 64,
  parameter logic [7:0] WIPER_RESET  = 8'h80
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [2:0]              addr_pins,
  output logic                    sda_oe,
  output logic [NUM_WIPERS*8-1:0] wiper_o
);
  import wiper_pkg::*;

  localparam int HW = $clog2(RESET_HOLD + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [HW-1:0] hold_cnt;
  logic          ready;
  bus_state_t    state;
  logic [3:0]    cnt;
  logic [7:0]    shreg, txsh, ptr, rd_data, wr_addr, wr_data;
  logic          rw, wr_en, busy;

  i2c_pin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  wiper_regfile #(
    .NUM_WIPERS(NUM_WIPERS), .STORE_CYCLES(STORE_CYCLES), .WIPER_RESET(WIPER_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .busy(busy), .wiper_flat(wiper_o)
  );

  assign ready = (hold_cnt == HW'(RESET_HOLD));

  always_ff @(posedge clk) begin
    if (rst)         hold_cnt <= '0;
    else if (!ready) hold_cnt <= hold_cnt + HW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      txsh    <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det && ready) begin
        state  <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_REG, S_WDATA: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == S_DEV) begin
                if (shreg[7:4] == ID_PREFIX && shreg[3:1] == addr_pins) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= S_DEV_ACK;
                end else begin
                  state <= S_WAIT;
                end
              end else if (state == S_REG) begin
                ptr    <= shreg;
                sda_oe <= 1'b1;
                state  <= S_REG_ACK;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                sda_oe  <= 1'b1;
                state   <= S_WDATA_ACK;
              end
            end
          end
          S_DEV_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                state  <= S_RDATA;
                sda_oe <= ~rd_data[7];
                txsh   <= {rd_data[6:0], 1'b0};
                cnt    <= 4'd1;
              end else begin
                state  <= S_REG;
                sda_oe <= 1'b0;
              end
            end
          end
          S_REG_ACK, S_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= S_WDATA;
              if (state == S_WDATA_ACK) ptr <= ptr + 8'd1;
            end
          end
          S_RDATA: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else begin
                sda_oe <= ~txsh[7];
                txsh   <= {txsh[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              if (sda_s) state <= S_WAIT;
              else       ptr   <= ptr + 8'd1;
            end else if (scl_fall) begin
              state  <= S_RDATA;
              sda_oe <= ~rd_data[7];
              txsh   <= {rd_data[6:0], 1'b0};
              cnt    <= 4'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wiper_regs_chk.sv
module i2c_wiper_regs_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         sda_oe,
  input logic         scl_s,
  input logic         start_det,
  input logic         stop_det,
  input logic         ready,
  input logic         wr_en,
  input logic         busy,
  input logic [7:0]   wr_addr,
  input logic [7:0]   wr_data,
  input logic [W-1:0] wiper_o
);
  import wiper_pkg::*;

  AST_DRIVE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(start_det || stop_det)) |-> !$past(scl_s)); // R12

  AST_COND_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (stop_det || (start_det && ready)) |=> !sda_oe); // R2

  AST_QUIET_BEFORE_READY: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !sda_oe); // R11

  AST_BUSY_FREEZES_WIPERS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> $stable(wiper_o)); // R10

  AST_STORE_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_addr == CTRL_ADDR && wr_data[STORE_BIT]) |=> busy); // R9
endmodule

bind i2c_wiper_regs i2c_wiper_regs_chk #(.W(NUM_WIPERS*8)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .ready(ready),
  .wr_en(wr_en), .busy(busy), .wr_addr(wr_addr), .wr_data(wr_data),
  .wiper_o(wiper_o)
);

// File: tb/i2c_wiper_regs_test.sv
module i2c_wiper_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 20;
  localparam int NW         = 4;
  localparam int STORE      = 8000;
  localparam int HOLD       = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] pins = 3'b101;
  logic sda_oe;
  logic [NW*8-1:0] wiper_o;
  wire  sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_wiper_regs #(.NUM_WIPERS(NW), .STORE_CYCLES(STORE), .RESET_HOLD(HOLD)) uut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .addr_pins(pins), .sda_oe(sda_oe), .wiper_o(wiper_o)
  );

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  string tag_q[$];
  int obs_q[$];
  bit oe_seen = 1'b0;
  int high_moves = 0;
  logic oe_prev = 1'b0;

  always @(posedge clk) begin
    if (sda_oe === 1'b1) oe_seen = 1'b1;
    if (!rst && sda_oe !== oe_prev && m_scl === 1'b1) high_moves++;
    oe_prev = sda_oe;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    while (obs_q.size() > 0) begin
      int a;
      a = obs_q.pop_front();
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unmatched item actual=%0h expected=none", a);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (a != e) begin
          errors++;
          $display("FAIL %s actual=%0h expected=%0h", t, a, e);
        end
      end
    end
  end

  task automatic wait_clk(int n); repeat (n) @(negedge clk); endtask
  task automatic expect_item(int v, string t); exp_q.push_back(v); tag_q.push_back(t); endtask
  task automatic observe(int v); obs_q.push_back(v); endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clk(Q/2);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(Q/2);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b1; wait_clk(Q);
  endtask

  task automatic send_bit(logic b);
    m_sda = b; wait_clk(Q/2);
    m_scl = 1'b1; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q/2);
  endtask

  task automatic recv_bit(output logic b, output logic oe);
    m_sda = 1'b1; wait_clk(Q/2);
    m_scl = 1'b1; wait_clk(Q/2);
    b = sda_line; oe = sda_oe;
    wait_clk(Q/2);
    m_scl = 1'b0; wait_clk(Q/2);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic b, oe;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b, oe);
    ack = ~b;
  endtask

  task automatic wr_byte(logic [7:0] v, int exp_ack, string t);
    logic ack;
    expect_item(exp_ack, t);
    send_byte(v, ack);
    observe(int'(ack));
  endtask

  task automatic rd_byte(logic [7:0] exp_v, bit host_ack, string t);
    logic [7:0] val;
    logic b, oe;
    expect_item(int'(exp_v), t);
    expect_item(0, "R6 SDA released on host acknowledge clock");
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b, oe);
      val[i] = b;
    end
    m_sda = ~host_ack; wait_clk(Q/2);
    m_scl = 1'b1; wait_clk(Q/2);
    oe = sda_oe;
    wait_clk(Q/2);
    m_scl = 1'b0; wait_clk(Q/2);
    observe(int'(val));
    observe(int'(oe));
  endtask

  task automatic write1(logic [7:0] a, logic [7:0] d, string t);
    bus_start();
    wr_byte(8'hAA, 1, "R5 ack on identification byte");
    wr_byte(a, 1, "R5 ack on pointer byte");
    wr_byte(d, 1, t);
    bus_stop();
  endtask

  task automatic read1(logic [7:0] a, logic [7:0] exp_v, string t);
    bus_start();
    wr_byte(8'hAA, 1, "R5 ack on identification byte");
    wr_byte(a, 1, "R5 ack on pointer byte");
    bus_start();
    wr_byte(8'hAB, 1, "R4 read identification acked");
    rd_byte(exp_v, 1'b0, t);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic ack, b, oe;
    wait_clk(5);
    expect_item(0, "R11 SDA released in reset");
    observe(int'(sda_oe));
    expect_item(32'h80808080, "R11 wipers reset to 0x80");
    observe(int'(wiper_o));
    rst = 1'b0;

    // START inside the hold window is ignored
    bus_start();
    wr_byte(8'hAA, 0, "R11 START during hold window ignored");
    bus_stop();
    wait_clk(HOLD);

    write1(8'h01, 8'hC5, "R5 ack on write data");
    expect_item(8'hC5, "R1 wiper1 holds byte sent MSB first");
    observe(int'(wiper_o[15:8]));

    // identification mismatches
    bus_start();
    wr_byte(8'hA8, 0, "R4 strap mismatch NACKed");
    wr_byte(8'h02, 0, "R4 bus ignored after mismatch");
    bus_stop();
    bus_start();
    wr_byte(8'h2A, 0, "R4 prefix mismatch NACKed");
    bus_stop();

    // burst write with pointer increment
    bus_start();
    wr_byte(8'hAA, 1, "R5 ack on identification byte");
    wr_byte(8'h02, 1, "R5 ack on pointer byte");
    wr_byte(8'h11, 1, "R5 ack first burst byte");
    wr_byte(8'h22, 1, "R5 ack second burst byte");
    bus_stop();
    expect_item(8'h11, "R8 wiper2 written");
    observe(int'(wiper_o[23:16]));
    expect_item(8'h22, "R8 pointer advanced to wiper3");
    observe(int'(wiper_o[31:24]));

    // burst read with repeated START, then host NACK
    bus_start();
    wr_byte(8'hAA, 1, "R5 ack on identification byte");
    wr_byte(8'h01, 1, "R5 ack on pointer byte");
    bus_start();
    wr_byte(8'hAB, 1, "R2 repeated START accepted");
    rd_byte(8'hC5, 1'b1, "R6 read wiper1 MSB first (R1)");
    rd_byte(8'h11, 1'b1, "R6 pointer advanced on host ack");
    rd_byte(8'h22, 1'b0, "R7 last byte before NACK");
    oe_seen = 1'b0;
    for (int i = 0; i < 9; i++) recv_bit(b, oe);
    expect_item(0, "R7 SDA stays released after host NACK");
    observe(int'(oe_seen));
    bus_stop();

    // unmapped pointer
    write1(8'h10, 8'h77, "R8 unmapped write still acked");
    read1(8'h10, 8'h00, "R8 unmapped reads zero");
    expect_item(32'h2211C580, "R8 unmapped write left wipers alone");
    observe(int'(wiper_o));

    // traffic without START after STOP
    oe_seen = 1'b0;
    send_byte(8'hAA, ack);
    send_byte(8'h01, ack);
    expect_item(0, "R3 no drive without START");
    observe(int'(oe_seen));
    bus_stop();

    // nonvolatile store window
    write1(8'h08, 8'h85, "R9 store request acked");
    read1(8'h08, 8'h25, "R9 busy flag set, request bit reads 0");
    write1(8'h00, 8'h55, "R10 data acked while busy");
    expect_item(8'h80, "R10 wiper0 unchanged while busy");
    observe(int'(wiper_o[7:0]));
    write1(8'h08, 8'h03, "R10 ctrl data acked while busy");
    read1(8'h08, 8'h25, "R10 ctrl unchanged while busy");
    wait_clk(STORE);
    read1(8'h08, 8'h05, "R9 busy cleared after timer");
    write1(8'h00, 8'h55, "R10 write after store acked");
    expect_item(8'h55, "R10 wiper0 written after busy clears");
    observe(int'(wiper_o[7:0]));

    // repeated START inside a write
    bus_start();
    wr_byte(8'hAA, 1, "R5 ack on identification byte");
    wr_byte(8'h03, 1, "R5 ack on pointer byte");
    bus_start();
    wr_byte(8'hAA, 1, "R2 restart mid write");
    wr_byte(8'h03, 1, "R5 ack on pointer byte");
    wr_byte(8'h9A, 1, "R5 ack on write data");
    bus_stop();
    expect_item(8'h9A, "R2 write after repeated START lands");
    observe(int'(wiper_o[31:24]));

    expect_item(0, "R12 drive changes while SCL high");
    observe(high_moves);

    wait_clk(4);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard left %0d expected items actual=%0d expected=0", exp_q.size(), exp_q.size());
    end
    finish_run();
  end
endmodule